// File: doc/BRIEF.md
# Dual Maskable Interrupt Aggregator

This block gathers single-cycle event indications from an audio receiver and its companion converter and turns them into two interrupt lines. Each line keeps its own set of event latches, its own mask register and its own configuration. An event is latched on the rising edge of its input. A line asserts when at least one latched event is not masked. Software reads a line's status, which returns the latched events before masking. That read clears the line's latches and so releases the interrupt.

Six sources are provided by default: sample-rate change, burst-preamble renewal, channel-status renewal, compressed-stream detection, emphasis-flag change and converter level crossing. The level-crossing source feeds only the second line. Each output pin can instead pass a raw flag: the error flag on the first pin and the non-PCM flag on the second. Each pin also has a polarity inversion and an output-enable that can be turned off to leave the pin floating. The host bus that issues the writes and read strobes lies outside this block.

Top module: `dual_irq_aggregator`

## Requirements
- R1: After reset every mask bit is 1 (masked), every status bit is 0, both pins pass their raw flag active-high, and both output enables are 1.
- R2: A 0-to-1 transition on `evt_i[k]` sets latch k of each line that accepts source k. An input held high does not set the latch again after it has been cleared.
- R3: With a pin in interrupt mode and active-high, the pin is 1 exactly when some latched event of that line has its mask bit at 0.
- R4: Source index 5 (level crossing) is accepted by line 1 only. Line 0 status bit 5 always reads 0 and never raises pin 0.
- R5: When `rd_en` is high, `rd_data` shows the status of the line chosen by `rd_line` (0 or 1). At that clock edge the chosen line's latches clear, and the other line is untouched.
- R6: An event whose rising edge falls in the same cycle as a clearing read of its line is latched, not lost.
- R7: Status reports latched events regardless of their mask bits.
- R8: Configuration bit 0 selects the pin source: 0 passes the raw flag (`err_flag_i` on pin 0, `npcm_flag_i` on pin 1), 1 passes the line's interrupt.
- R9: Configuration bit 1 set to 1 inverts the pin level in either source mode.
- R10: Configuration bit 2 set to 1 drives the pin's output enable to 0. Otherwise the enable is 1.
- R11: Register writes use `wr_addr` 0 for the line 0 mask, 1 for the line 1 mask, 2 for the line 0 configuration and 3 for the line 1 configuration. A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NSRC | Event inputs, latched on rising edge |
| err_flag_i | input | 1 | Raw error flag for pin 0 |
| npcm_flag_i | input | 1 | Raw non-PCM flag for pin 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (R11) |
| wr_data | input | NSRC | Write data: mask bits, or config in bits 2:0 |
| rd_en | input | 1 | Status read strobe, clears the chosen line |
| rd_line | input | 1 | Line chosen for the read |
| rd_data | output | NSRC | Latched status of the chosen line |
| pin0_o | output | 1 | Pin 0 level |
| pin0_oe | output | 1 | Pin 0 output enable |
| pin1_o | output | 1 | Pin 1 level |
| pin1_oe | output | 1 | Pin 1 output enable |

## Verification
The assertions assume the event inputs are synchronous to `clk`, so a single-cycle high is a valid rising edge. They also assume that a read strobe lasts one cycle per intended clear. The stimulus drives every input on the falling clock edge and holds each read strobe for exactly one cycle. Events are raised either as one-cycle pulses or as a held level, which exercises the rising-edge rule. One event is placed deliberately in the same cycle as a clearing read.

// File: rtl/irq_agg_pkg.sv
// Package: shared types for the dual interrupt aggregator.
// Assumes two lines; register addresses are fixed by the write decode.
package irq_agg_pkg;

    localparam int unsigned NLINES = 2;

    typedef enum logic [1:0] {
        ADDR_MASK0 = 2'd0,
        ADDR_MASK1 = 2'd1,
        ADDR_CFG0  = 2'd2,
        ADDR_CFG1  = 2'd3
    } reg_addr_t;

    typedef struct packed {
        logic hiz;      // bit 2: release the pin
        logic act_low;  // bit 1: invert pin level
        logic sel_irq;  // bit 0: 1 = interrupt, 0 = raw flag
    } pin_cfg_t;

    localparam int unsigned CFG_W = $bits(pin_cfg_t);

endpackage

// File: rtl/irq_edge_detect.sv
// Module: rising-edge detector for a vector of synchronous event inputs.
// Assumes inputs are already in the clk domain; one-cycle output per rise.
module irq_edge_detect #(
    parameter int unsigned NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    output logic [NSRC-1:0] rise_o
);
    logic [NSRC-1:0] evt_q;

    // Remember last cycle's input levels.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_i;
    end

    // A rise is high now and low one cycle earlier.
    always_comb rise_o = evt_i & ~evt_q;
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: mask and pin configuration registers for both lines.
// Assumes one write per cycle; masks reset to all-masked, config to raw mode.
module irq_cfg_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned NSRC = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [NSRC-1:0]             wr_data,
    output logic [NLINES-1:0][NSRC-1:0] mask_o,
    output pin_cfg_t [NLINES-1:0]       cfg_o
);
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam logic [1:0] MASK_A = 2'(g);
        localparam logic [1:0] CFG_A  = 2'(g + 2);

        // Mask register of line g.
        always_ff @(posedge clk) begin
            if (!rst_n)                           mask_o[g] <= '1;
            else if (wr_en && wr_addr == MASK_A)  mask_o[g] <= wr_data;
        end

        // Pin configuration register of line g.
        always_ff @(posedge clk) begin
            if (!rst_n)                           cfg_o[g] <= '0;
            else if (wr_en && wr_addr == CFG_A)   cfg_o[g] <= pin_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end
endmodule

// File: rtl/irq_line.sv
// Module: one interrupt line: event latches, read-clear and masked OR.
// Assumes clr_i is a one-cycle strobe; SRC_EN marks accepted sources.
module irq_line #(
    parameter int unsigned     NSRC   = 6,
    parameter logic [NSRC-1:0] SRC_EN = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] rise_i,
    input  logic            clr_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] status_o,
    output logic            irq_o
);
    logic [NSRC-1:0] latch_q;
    logic [NSRC-1:0] set_v;

    // New events accepted by this line.
    always_comb set_v = rise_i & SRC_EN;

    // Latch events; a clear never drops an event arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (clr_i) latch_q <= set_v;
        else            latch_q <= latch_q | set_v;
    end

    // Unmasked pending events raise the line.
    always_comb begin
        status_o = latch_q;
        irq_o    = |(latch_q & ~mask_i);
    end

    // R6: an accepted rise is always present one cycle later.
    p_keep_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((latch_q & $past(set_v)) == $past(set_v)));

    // R2: without a clear, no latched event drops.
    p_hold_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    // R4: sources outside SRC_EN never appear.
    p_unused_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~SRC_EN) == '0);
endmodule

// File: rtl/irq_pin_mux.sv
// Module: output stage of one pin: source select, polarity, enable.
// Assumes raw_i is synchronous; purely combinational.
module irq_pin_mux
    import irq_agg_pkg::*;
(
    input  logic     irq_i,
    input  logic     raw_i,
    input  pin_cfg_t cfg_i,
    output logic     pin_o,
    output logic     oe_o
);
    // Pick the source, apply polarity, derive the enable.
    always_comb begin
        pin_o = (cfg_i.sel_irq ? irq_i : raw_i) ^ cfg_i.act_low;
        oe_o  = ~cfg_i.hiz;
    end
endmodule

// File: rtl/dual_irq_aggregator.sv
// Module: top of the dual interrupt aggregator.
// Assumes synchronous inputs; LVL_IDX names the source seen by line 1 only.
module dual_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NSRC    = 6,
    parameter int unsigned LVL_IDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            err_flag_i,
    input  logic            npcm_flag_i,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [NSRC-1:0] wr_data,
    input  logic            rd_en,
    input  logic            rd_line,
    output logic [NSRC-1:0] rd_data,
    output logic            pin0_o,
    output logic            pin0_oe,
    output logic            pin1_o,
    output logic            pin1_oe
);
    localparam logic [NSRC-1:0] LVL_BIT = {{(NSRC-1){1'b0}}, 1'b1} << LVL_IDX;
    localparam logic [NSRC-1:0] EN0     = ~LVL_BIT;
    localparam logic [NSRC-1:0] EN1     = '1;

    logic [NSRC-1:0]             rise;
    logic [NLINES-1:0][NSRC-1:0] mask;
    pin_cfg_t [NLINES-1:0]       cfg;
    logic [NLINES-1:0][NSRC-1:0] st;
    logic [NLINES-1:0]           irq;
    logic [NLINES-1:0]           raw;
    logic [NLINES-1:0]           pin_v;
    logic [NLINES-1:0]           oe_v;

    irq_edge_detect #(.NSRC(NSRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rise_o(rise)
    );

    irq_cfg_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mask_o(mask), .cfg_o(cfg)
    );

    // Raw flag per pin.
    always_comb raw = {npcm_flag_i, err_flag_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam logic [NSRC-1:0] EN_G = (g == 0) ? EN0 : EN1;
        logic clr;

        // Clear this line when it is the one being read.
        always_comb clr = rd_en && (rd_line == 1'(g));

        irq_line #(.NSRC(NSRC), .SRC_EN(EN_G)) u_line (
            .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr),
            .mask_i(mask[g]), .status_o(st[g]), .irq_o(irq[g])
        );

        irq_pin_mux u_pin (
            .irq_i(irq[g]), .raw_i(raw[g]), .cfg_i(cfg[g]),
            .pin_o(pin_v[g]), .oe_o(oe_v[g])
        );

        // R3: interrupt-mode active-high pin equals unmasked pending events.
        p_irq_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g].sel_irq && !cfg[g].act_low) |-> (pin_v[g] == |(st[g] & ~mask[g])));
    end

    // Status read mux and pin outputs.
    always_comb begin
        rd_data = st[rd_line];
        pin0_o  = pin_v[0];
        pin0_oe = oe_v[0];
        pin1_o  = pin_v[1];
        pin1_oe = oe_v[1];
    end

    // R1: first cycle out of reset, everything masked and nothing pending.
    p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask[0] == '1 && mask[1] == '1 && st[0] == '0 && st[1] == '0));

    // R5: a read of one line leaves the other line's latches intact.
    p_other_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_line) |=> ((st[0] & $past(st[0])) == $past(st[0])));
endmodule

// File: tb/dual_irq_aggregator_tb.sv
`timescale 1ns/1ps
module dual_irq_aggregator_tb;
    localparam int NSRC = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic            err_flag_i = 1'b0;
    logic            npcm_flag_i = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = '0;
    logic [NSRC-1:0] wr_data = '0;
    logic            rd_en = 1'b0;
    logic            rd_line = 1'b0;
    logic [NSRC-1:0] rd_data;
    logic            pin0_o, pin0_oe, pin1_o, pin1_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_irq_aggregator #(.NSRC(NSRC), .LVL_IDX(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .err_flag_i(err_flag_i),
        .npcm_flag_i(npcm_flag_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_line(rd_line), .rd_data(rd_data),
        .pin0_o(pin0_o), .pin0_oe(pin0_oe), .pin1_o(pin1_o), .pin1_oe(pin1_oe)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NSRC-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic line, output logic [NSRC-1:0] d);
        @(negedge clk); rd_en = 1'b1; rd_line = line;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
        #1;
    endtask

    task automatic pulse(input int k);
        @(negedge clk); evt_i[k] = 1'b1;
        @(negedge clk); evt_i[k] = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [NSRC-1:0] d;
        #1;
        chk("R1 pin0_oe", 8'(pin0_oe), 8'h1);
        chk("R1 pin1_oe", 8'(pin1_oe), 8'h1);
        chk("R1 pin0 raw", 8'(pin0_o), 8'h0);
        rd(1'b0, d); chk("R1 status0", 8'(d), 8'h00);
        wr(2'd2, 6'b001); wr(2'd3, 6'b001);
        pulse(0);
        chk("R1 masked pin0", 8'(pin0_o), 8'h0);
        chk("R1 masked pin1", 8'(pin1_o), 8'h0);
        rd(1'b0, d); chk("R7 status0 masked src", 8'(d), 8'h01);
        rd(1'b1, d); chk("R5 line1 kept", 8'(d), 8'h01);
    endtask

    task automatic t_mask();
        logic [NSRC-1:0] d;
        wr(2'd0, 6'h3B);
        pulse(3);
        chk("R3 masked src", 8'(pin0_o), 8'h0);
        pulse(2);
        chk("R3 unmasked src", 8'(pin0_o), 8'h1);
        chk("R11 line1 mask unchanged", 8'(pin1_o), 8'h0);
        rd(1'b0, d); chk("R7 status0", 8'(d), 8'h0C);
        chk("R5 pin0 cleared", 8'(pin0_o), 8'h0);
        rd(1'b1, d); chk("R2 line1 status", 8'(d), 8'h0C);
    endtask

    task automatic t_level();
        logic [NSRC-1:0] d;
        wr(2'd1, 6'h1F);
        pulse(5);
        chk("R4 pin1 raised", 8'(pin1_o), 8'h1);
        chk("R4 pin0 quiet", 8'(pin0_o), 8'h0);
        rd(1'b0, d); chk("R4 status0 bit5", 8'(d), 8'h00);
        rd(1'b1, d); chk("R4 status1", 8'(d), 8'h20);
        chk("R5 pin1 cleared", 8'(pin1_o), 8'h0);
    endtask

    task automatic t_held();
        logic [NSRC-1:0] d;
        @(negedge clk); evt_i[1] = 1'b1;
        repeat (2) @(negedge clk);
        rd(1'b0, d); chk("R2 held first", 8'(d), 8'h02);
        rd(1'b0, d); chk("R2 held no reset", 8'(d), 8'h00);
        @(negedge clk); evt_i[1] = 1'b0;
        rd(1'b1, d); chk("R2 held line1", 8'(d), 8'h02);
    endtask

    task automatic t_coincide();
        logic [NSRC-1:0] d;
        @(negedge clk); rd_en = 1'b1; rd_line = 1'b0; evt_i[4] = 1'b1;
        #1 d = rd_data;
        chk("R6 before edge", 8'(d), 8'h00);
        @(negedge clk); rd_en = 1'b0; evt_i[4] = 1'b0;
        rd(1'b0, d); chk("R6 kept on clear", 8'(d), 8'h10);
        rd(1'b1, d); chk("R6 line1", 8'(d), 8'h10);
    endtask

    task automatic t_polarity();
        logic [NSRC-1:0] d;
        wr(2'd2, 6'b011);
        #1 chk("R9 idle high", 8'(pin0_o), 8'h1);
        pulse(2);
        chk("R9 active low", 8'(pin0_o), 8'h0);
        rd(1'b0, d);
        chk("R9 released", 8'(pin0_o), 8'h1);
        rd(1'b1, d);
    endtask

    task automatic t_hiz();
        wr(2'd2, 6'b111);
        #1 chk("R10 pin0 off", 8'(pin0_oe), 8'h0);
        chk("R11 pin1 on", 8'(pin1_oe), 8'h1);
        wr(2'd2, 6'b000);
        #1 chk("R10 pin0 on", 8'(pin0_oe), 8'h1);
    endtask

    task automatic t_raw();
        wr(2'd3, 6'b000);
        @(negedge clk); err_flag_i = 1'b1; npcm_flag_i = 1'b0;
        #1 chk("R8 pin0 err", 8'(pin0_o), 8'h1);
        chk("R8 pin1 npcm", 8'(pin1_o), 8'h0);
        @(negedge clk); err_flag_i = 1'b0; npcm_flag_i = 1'b1;
        #1 chk("R8 pin0 err low", 8'(pin0_o), 8'h0);
        chk("R8 pin1 npcm high", 8'(pin1_o), 8'h1);
        wr(2'd3, 6'b010);
        #1 chk("R9 raw inverted", 8'(pin1_o), 8'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_level();
        t_held();
        t_coincide();
        t_polarity();
        t_hiz();
        t_raw();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule